// File: doc/BRIEF.md
# Row-Parallel Sum of Absolute Differences Engine

This block measures how closely a current 16x16 block of 8-bit pixels matches a reference block. Its measure is the total, over all 256 pixel pairs, of the absolute difference between the two pixels. A motion-estimation search feeds it one candidate at a time. For each candidate the caller raises `start` together with the first operand pair, streams the remaining pairs with `in_valid`, and reads `sad` when `done` pulses.

There are two modes, chosen when a block starts. In the row-parallel mode each issued operation carries a full 128-bit row of sixteen pixels from each block. The engine subtracts all sixteen lanes, takes their absolute values, reduces them in an adder tree and adds the row total to the running sum, all in one cycle. A block then needs sixteen operations. In the one-lane mode only the lowest pixel of each operand is used, and a block needs 256 operations.

Top module: `sad_engine`

## Requirements
- R1: When `rst_n` is low, `sad` reads 0 and `done` reads 0. Reset is asynchronous.
- R2: In row-parallel mode (`scalar_mode` = 0 at start), lane i is bits [8i+7:8i] of `cur_row` and `ref_row`, with lane pixels unsigned. Each accepted operation adds the sum of the sixteen lane absolute differences to `sad`.
- R3: In one-lane mode (`scalar_mode` = 1 at start), only bits [7:0] of each operand count. Bits above 7 have no effect on `sad`, and a block takes 256 operations.
- R4: A cycle with `start` high clears the running sum. If `in_valid` is also high in that cycle, the operand pair is accepted as the block's first operation.
- R5: `done` is high for exactly one cycle, the cycle after the block's last operation (the 16th in row-parallel mode, the 256th in one-lane mode) is accepted. In that cycle `sad` holds the block total.
- R6: A cycle with `in_valid` low and `start` low leaves `sad` unchanged, so gaps in the stream do not alter the total.
- R7: Once a block has completed, operations with `in_valid` high and no `start` are ignored. `sad` keeps its total until the next start.
- R8: The running sum never wraps. A block of all 0 against all 255 gives 65280.
- R9: The mode is taken from `scalar_mode` in the start cycle. Changes to `scalar_mode` later in the block have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears the sum and opens a new block |
| scalar_mode | input | 1 | 1 selects one-lane mode, sampled at start |
| in_valid | input | 1 | Operand pair present this cycle |
| cur_row | input | 128 | Current-block operand, sixteen 8-bit lanes |
| ref_row | input | 128 | Reference-block operand, sixteen 8-bit lanes |
| done | output | 1 | One-cycle pulse when the block total is ready |
| sad | output | 16 | Running and final sum of absolute differences |

## Verification
An operation accepted at one rising edge shows up in `sad` just after that edge, so both the running sum and the `done` pulse can be read one cycle after the operand is driven. The bench drives on falling edges and reads the final total and `done` at the falling edge after the last operand's accepting edge. It then confirms at the following falling edge that `done` has dropped. Ignored-input and gap cases are read at a falling edge after the extra stimulus, before any new start. Reset is asynchronous, so its effect is read at the first falling edge after `rst_n` goes low.

// File: rtl/sad_engine.sv
module sad_engine #(
  parameter int PIX_W = 8,
  parameter int LANES = 16,
  parameter int ROWS  = 16,
  localparam int DW    = PIX_W * LANES,
  localparam int SAD_W = $clog2(ROWS * LANES * ((1 << PIX_W) - 1) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             scalar_mode,
  input  logic             in_valid,
  input  logic [DW-1:0]    cur_row,
  input  logic [DW-1:0]    ref_row,
  output logic             done,
  output logic [SAD_W-1:0] sad
);
  localparam int RS_W       = $clog2(LANES * ((1 << PIX_W) - 1) + 1);
  localparam int SIMD_OPS   = ROWS;
  localparam int SCALAR_OPS = ROWS * LANES;
  localparam int CNT_W      = $clog2(SCALAR_OPS + 1);

  logic             mode_q, active;
  logic [CNT_W-1:0] cnt;
  logic [SAD_W-1:0] acc;
  logic [PIX_W-1:0] lane_abs [LANES];
  logic [RS_W-1:0]  row_sum;

  wire              mode_eff = start ? scalar_mode : mode_q;
  wire              accept   = in_valid & (active | start);
  wire [CNT_W-1:0]  cnt_base = start ? '0 : cnt;
  wire [CNT_W-1:0]  target   = mode_eff ? CNT_W'(SCALAR_OPS) : CNT_W'(SIMD_OPS);
  wire              last     = accept & (cnt_base == target - 1'b1);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wire [PIX_W:0] diff = {1'b0, cur_row[i*PIX_W +: PIX_W]} - {1'b0, ref_row[i*PIX_W +: PIX_W]};
    wire [PIX_W:0] mag  = diff[PIX_W] ? -diff : diff;
    wire           keep = (i == 0) | ~mode_eff;
    assign lane_abs[i] = keep ? mag[PIX_W-1:0] : '0;
  end

  always_comb begin
    row_sum = '0;
    for (int i = 0; i < LANES; i++) row_sum = row_sum + RS_W'(lane_abs[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      cnt    <= '0;
      mode_q <= 1'b0;
      active <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= last;
      if (start) begin
        mode_q <= scalar_mode;
        acc    <= accept ? SAD_W'(row_sum) : '0;
        cnt    <= accept ? CNT_W'(1) : '0;
        active <= ~last;
      end else if (accept) begin
        acc <= acc + SAD_W'(row_sum);
        cnt <= cnt + 1'b1;
        if (last) active <= 1'b0;
      end
    end
  end

  assign sad = acc;
endmodule

module sad_engine_chk #(
  parameter int SAD_W = 16,
  parameter int MAX_ROW = 4080
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             in_valid,
  input logic             done,
  input logic [SAD_W-1:0] sad
);
  always @(negedge clk)
    if (!rst_n) assert_reset_clear_R1: assert (sad == '0 && !done);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> sad <= SAD_W'(MAX_ROW));

  assert_gap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !start) |=> $stable(sad));

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> sad >= $past(sad));

  assert_hold_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(sad));
endmodule

bind sad_engine sad_engine_chk #(.SAD_W(SAD_W), .MAX_ROW(LANES * ((1 << PIX_W) - 1))) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .done(done), .sad(sad));

// File: tb/test_sad_engine.sv
module test_sad_engine;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         start = 1'b0, scalar_mode = 1'b0, in_valid = 1'b0;
  logic [127:0] cur_row = '0, ref_row = '0;
  logic         done;
  logic [15:0]  sad;
  int           n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  sad_engine i_sad_engine (.clk(clk), .rst_n(rst_n), .start(start), .scalar_mode(scalar_mode),
    .in_valid(in_valid), .cur_row(cur_row), .ref_row(ref_row), .done(done), .sad(sad));

  typedef struct packed {
    logic       scalar;
    logic [1:0] kc; logic [7:0] sc;
    logic [1:0] kr; logic [7:0] sr;
    logic       gaps; logic flip;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 2'd0, 8'd0,   2'd0, 8'd255, 1'b0, 1'b0},
    '{1'b0, 2'd0, 8'd255, 2'd0, 8'd0,   1'b0, 1'b0},
    '{1'b0, 2'd1, 8'd3,   2'd1, 8'd10,  1'b0, 1'b0},
    '{1'b0, 2'd2, 8'd5,   2'd2, 8'd200, 1'b1, 1'b0},
    '{1'b1, 2'd2, 8'd9,   2'd2, 8'd77,  1'b0, 1'b0},
    '{1'b1, 2'd0, 8'd0,   2'd0, 8'd255, 1'b0, 1'b1},
    '{1'b0, 2'd2, 8'd44,  2'd2, 8'd44,  1'b0, 1'b1},
    '{1'b1, 2'd1, 8'd0,   2'd2, 8'd1,   1'b1, 1'b0}
  };

  function automatic logic [7:0] pix(logic [1:0] k, logic [7:0] s, int r, int l);
    logic [7:0] a, b, c;
    a = 8'(s * 29); b = 8'(r * 113); c = 8'(l * 71);
    case (k)
      2'd0:    return s;
      2'd1:    return 8'(s + r * 16 + l);
      default: return (a ^ b) + c;
    endcase
  endfunction

  function automatic int exp_sad(vec_t v);
    int t = 0;
    for (int r = 0; r < 16; r++)
      for (int l = 0; l < 16; l++) begin
        int a = pix(v.kc, v.sc, r, l);
        int b = pix(v.kr, v.sr, r, l);
        t += (a > b) ? a - b : b - a;
      end
    return t;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_block(vec_t v, string req);
    int nops = v.scalar ? 256 : 16;
    int early = 0;
    for (int i = 0; i < nops; i++) begin
      if (v.gaps && i % 3 == 1) begin
        @(negedge clk); start = 0; in_valid = 0; cur_row = {16{8'h5A}}; ref_row = '1;
      end
      @(negedge clk);
      if (i > 0 && done) early++;
      start = (i == 0);
      in_valid = 1;
      scalar_mode = (i == 0) ? v.scalar : (v.flip ? ~v.scalar : v.scalar);
      if (v.scalar) begin
        cur_row = {{15{8'hC3}}, pix(v.kc, v.sc, i / 16, i % 16)};
        ref_row = {{15{8'h00}}, pix(v.kr, v.sr, i / 16, i % 16)};
      end else
        for (int l = 0; l < 16; l++) begin
          cur_row[l*8 +: 8] = pix(v.kc, v.sc, i, l);
          ref_row[l*8 +: 8] = pix(v.kr, v.sr, i, l);
        end
    end
    @(negedge clk);
    start = 0; in_valid = 0;
    check({req, " no early done R5"}, early, 0);
    check({req, " done pulse R5"}, done, 1);
    check({req, " total R2/R3/R8/R9"}, sad, exp_sad(v));
    @(negedge clk);
    check({req, " done drops R5"}, done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 sad in reset", sad, 0);
    check("R1 done in reset", done, 0);
    rst_n = 1;

    foreach (VEC[k]) run_block(VEC[k], $sformatf("vec%0d", k));

    // R7: operands after completion are ignored
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); in_valid = 1; cur_row = '1; ref_row = '0;
    end
    @(negedge clk); in_valid = 0;
    check("R7 sad holds after block", sad, exp_sad(VEC[7]));
    check("R7 no done from ignored ops", done, 0);

    // R4: start alone clears
    @(negedge clk); start = 1; in_valid = 0;
    @(negedge clk); start = 0;
    check("R4 start without operand clears", sad, 0);

    // R6: idle cycles keep a partial total
    @(negedge clk); start = 1; in_valid = 1; scalar_mode = 0; cur_row = {16{8'd20}}; ref_row = {16{8'd5}};
    @(negedge clk); start = 0; in_valid = 0;
    check("R4 first operand accepted with start", sad, 240);
    repeat (4) @(negedge clk);
    check("R6 gap keeps sum", sad, 240);

    // R4: restart mid-block aborts the old block
    run_block(VEC[2], "restart R4");

    // R1: reset during a block
    @(negedge clk); start = 1; in_valid = 1; cur_row = '1; ref_row = '0;
    @(negedge clk); start = 0; in_valid = 1;
    #1 rst_n = 0;
    @(negedge clk); in_valid = 0;
    check("R1 mid-run reset sad", sad, 0);
    check("R1 mid-run reset done", done, 0);
    rst_n = 1;
    run_block(VEC[0], "after reset R1");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule